// File: doc/BRIEF.md
# Max-Min Fuzzy Rule Engine

This block is the arithmetic core of a single-input single-output fuzzy accelerator. It holds a rule base of eight 32-bit rows, one row for each element of the input universe. Fuzzy sets move in and out as packed words: eight grades of 4 bits each, giving 16 membership levels from 0 (none) to 15 (full).

A run starts with a one-cycle `start` pulse. The block samples the operation select and both operand words on that pulse, then works through one rule row per clock. In build mode it merges the relation min(X[i], Z[j]) into the stored rules by taking the element-wise maximum. In inference mode it composes X with the rule base by max-min composition. The fuzzy result is left as it is, with no defuzzification, and is presented on `z_out`. A separate read port returns any stored row, and `clear` wipes the rule base and stops any run in progress.

Top module: `fuzzy_rule_engine`

## Requirements
- R1: Grade i of a packed word sits in bits 4i+3..4i. Row i of the rule base holds R[i][j] at bits 4j+3..4j. Grades are unsigned: 0 is no membership and 15 is full membership.
- R2: A build run (`mode`=0) leaves every row set to R[i][j] = max(R[i][j], min(X[i], Z[j])).
- R3: Build runs accumulate. A row element never decreases, and successive runs with different operands merge into one rule base.
- R4: An inference run (`mode`=1) gives z_out[j] = max over i of min(X[i], R[i][j]), starting from an all-zero result.
- R5: If `start` is sampled at clock edge E0, `busy` is high from E0 to E8. `done` is high for exactly one cycle, after E8.
- R6: `z_out` changes only at the end of an inference run, where it takes the new result. Build runs leave it unchanged.
- R7: A `start` pulse while `busy` is high is ignored. The run in progress keeps its timing, its mode and its result.
- R8: `clear` zeroes all eight rule rows and the row counter and ends any run at the next edge, so no `done` follows. It has priority over `start`.
- R9: After reset, every rule row reads 0, `z_out` is 0, and `busy` and `done` are low.
- R10: `rd_row` shows rule row `rd_addr` combinationally, and each row can be read on its own.
- R11: `x_word`, `z_word` and `mode` are sampled only when a run is accepted. Changes to them during a run have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous wipe of the rule base and abort of any run |
| start | input | 1 | Begins a run when the block is idle |
| mode | input | 1 | 0 = build rules, 1 = inference |
| x_word | input | 32 | Packed input fuzzy set X |
| z_word | input | 32 | Packed output fuzzy set Z, used in build mode |
| rd_addr | input | 3 | Rule row to show on rd_row |
| rd_row | output | 32 | Content of rule row rd_addr |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| z_out | output | 32 | Registered inference result |

## Verification
The assertions assume that every input is synchronous to `clk`. They assume that `clear` may arrive in any cycle, including the cycle of the last row, and that `start` may be held or pulsed again while a run is active. The bench changes inputs only on falling edges and samples outputs there. Its stimulus covers those cases deliberately: `start` is re-asserted during a run with the operands and mode inverted, and `clear` is raised in the middle of a build run. Grade patterns include all-zero, all-full and single-element words, so every row position and both grade extremes are reached.

// File: rtl/fz_pkg.sv
package fz_pkg;
    typedef enum logic {
        OP_BUILD = 1'b0,
        OP_INFER = 1'b1
    } fz_op_e;
endpackage

// File: rtl/fz_row_unit.sv
// One rule row against one X grade: build update and inference partial max.
module fz_row_unit #(
    parameter int N_ELEM  = 8,
    parameter int GRADE_W = 4,
    localparam int WORD_W = N_ELEM * GRADE_W
) (
    input  logic [GRADE_W-1:0] x_grade,
    input  logic [WORD_W-1:0]  z_word,
    input  logic [WORD_W-1:0]  r_row,
    input  logic [WORD_W-1:0]  acc_in,
    output logic [WORD_W-1:0]  row_new,
    output logic [WORD_W-1:0]  acc_new
);
    for (genvar j = 0; j < N_ELEM; j++) begin : g_elem
        logic [GRADE_W-1:0] zj, rj, aj, m_build, m_infer;
        always_comb begin
            zj      = z_word[j*GRADE_W +: GRADE_W];
            rj      = r_row[j*GRADE_W +: GRADE_W];
            aj      = acc_in[j*GRADE_W +: GRADE_W];
            m_build = (x_grade < zj) ? x_grade : zj;
            m_infer = (x_grade < rj) ? x_grade : rj;
            row_new[j*GRADE_W +: GRADE_W] = (rj > m_build) ? rj : m_build;
            acc_new[j*GRADE_W +: GRADE_W] = (aj > m_infer) ? aj : m_infer;
        end
    end
endmodule

// File: rtl/fz_rule_bank.sv
// Eight-row rule store: one engine port, one independent read port.
module fz_rule_bank #(
    parameter int N_ELEM  = 8,
    parameter int GRADE_W = 4,
    localparam int WORD_W = N_ELEM * GRADE_W,
    localparam int ROW_W  = $clog2(N_ELEM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [ROW_W-1:0]  waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ROW_W-1:0]  raddr_a,
    output logic [WORD_W-1:0] rdata_a,
    input  logic [ROW_W-1:0]  raddr_b,
    output logic [WORD_W-1:0] rdata_b
);
    logic [N_ELEM-1:0][WORD_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (clr) begin
            mem_d = '0;
        end else if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];

    a_r8_clear_wipes: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (mem_q == '0));

    for (genvar j = 0; j < N_ELEM; j++) begin : g_mono
        a_r3_no_decrease: assert property (@(posedge clk) disable iff (!rst_n)
            (we && !clr) |=> (mem_q[$past(waddr)][j*GRADE_W +: GRADE_W]
                              >= $past(rdata_a[j*GRADE_W +: GRADE_W])));
    end
endmodule

// File: rtl/fz_ctrl.sv
// Run sequencer: operand capture, row counter, accumulator, result register.
module fz_ctrl #(
    parameter int N_ELEM  = 8,
    parameter int GRADE_W = 4,
    localparam int WORD_W = N_ELEM * GRADE_W,
    localparam int ROW_W  = $clog2(N_ELEM)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               start,
    input  logic               mode,
    input  logic [WORD_W-1:0]  x_word,
    input  logic [WORD_W-1:0]  z_word,
    input  logic [WORD_W-1:0]  acc_new,
    output logic [ROW_W-1:0]   row,
    output logic [GRADE_W-1:0] x_grade,
    output logic [WORD_W-1:0]  z_op,
    output logic [WORD_W-1:0]  acc,
    output logic               we,
    output logic               busy,
    output logic               done,
    output logic [WORD_W-1:0]  z_out
);
    import fz_pkg::*;

    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(N_ELEM - 1);

    typedef struct packed {
        logic              busy;
        logic              done;
        fz_op_e            op;
        logic [ROW_W-1:0]  row;
        logic [WORD_W-1:0] x;
        logic [WORD_W-1:0] z;
        logic [WORD_W-1:0] acc;
        logic [WORD_W-1:0] zout;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (clear) begin
            st_d.busy = 1'b0;
            st_d.row  = '0;
            st_d.acc  = '0;
        end else if (st_q.busy) begin
            st_d.acc = acc_new;
            if (st_q.row == LAST_ROW) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.row  = '0;
                if (st_q.op == OP_INFER) st_d.zout = acc_new;
            end else begin
                st_d.row = st_q.row + 1'b1;
            end
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.row  = '0;
            st_d.op   = fz_op_e'(mode);
            st_d.x    = x_word;
            st_d.z    = z_word;
            st_d.acc  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign row     = st_q.row;
    assign x_grade = st_q.x[st_q.row*GRADE_W +: GRADE_W];
    assign z_op    = st_q.z;
    assign acc     = st_q.acc;
    assign we      = st_q.busy && (st_q.op == OP_BUILD) && !clear;
    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign z_out   = st_q.zout;

    a_r5_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r5_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && row == LAST_ROW && !clear) |=> (done && !busy));
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !clear && row != LAST_ROW) |=> (busy && row == $past(row) + 1'b1));
    a_r8_clear_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!busy && !done && row == '0));
    a_r6_zout_only_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        (z_out != $past(z_out)) |-> (done && st_q.op == OP_INFER));
endmodule

// File: rtl/fuzzy_rule_engine.sv
// Top: sequencer, row datapath and rule store.
module fuzzy_rule_engine #(
    parameter int N_ELEM  = 8,
    parameter int GRADE_W = 4,
    localparam int WORD_W = N_ELEM * GRADE_W,
    localparam int ROW_W  = $clog2(N_ELEM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              start,
    input  logic              mode,
    input  logic [WORD_W-1:0] x_word,
    input  logic [WORD_W-1:0] z_word,
    input  logic [ROW_W-1:0]  rd_addr,
    output logic [WORD_W-1:0] rd_row,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] z_out
);
    logic [ROW_W-1:0]   row;
    logic [GRADE_W-1:0] x_grade;
    logic [WORD_W-1:0]  z_op, acc, acc_new, row_cur, row_new;
    logic               we;

    fz_ctrl #(.N_ELEM(N_ELEM), .GRADE_W(GRADE_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .clear(clear), .start(start), .mode(mode),
        .x_word(x_word), .z_word(z_word), .acc_new(acc_new),
        .row(row), .x_grade(x_grade), .z_op(z_op), .acc(acc), .we(we),
        .busy(busy), .done(done), .z_out(z_out)
    );

    fz_row_unit #(.N_ELEM(N_ELEM), .GRADE_W(GRADE_W)) u_row (
        .x_grade(x_grade), .z_word(z_op), .r_row(row_cur), .acc_in(acc),
        .row_new(row_new), .acc_new(acc_new)
    );

    fz_rule_bank #(.N_ELEM(N_ELEM), .GRADE_W(GRADE_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .clr(clear), .we(we), .waddr(row),
        .wdata(row_new), .raddr_a(row), .rdata_a(row_cur),
        .raddr_b(rd_addr), .rdata_b(rd_row)
    );
endmodule

// File: tb/fuzzy_rule_engine_test.sv
module fuzzy_rule_engine_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 1'b0;
    logic        start = 1'b0;
    logic        mode = 1'b0;
    logic [31:0] x_word = '0;
    logic [31:0] z_word = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_row;
    logic        busy, done;
    logic [31:0] z_out;

    int n_checks = 0;
    int n_fail = 0;
    logic [31:0] ref_r [8];
    logic [31:0] ref_zout = '0;
    logic [31:0] expq [$];
    bit finished = 1'b0;

    fuzzy_rule_engine uut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .start(start), .mode(mode),
        .x_word(x_word), .z_word(z_word), .rd_addr(rd_addr), .rd_row(rd_row),
        .busy(busy), .done(done), .z_out(z_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] gr(input logic [31:0] w, input int i);
        return w[i*4 +: 4];
    endfunction

    // R2/R3 reference: element-wise max of old rule and min(X[i], Z[j])
    task automatic ref_build(input logic [31:0] xw, input logic [31:0] zw);
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                logic [3:0] m;
                m = (gr(xw, i) < gr(zw, j)) ? gr(xw, i) : gr(zw, j);
                if (m > gr(ref_r[i], j)) ref_r[i][j*4 +: 4] = m;
            end
        end
    endtask

    // R4 reference: max over rows of min(X[i], R[i][j])
    function automatic logic [31:0] ref_infer(input logic [31:0] xw);
        logic [31:0] res = '0;
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                logic [3:0] m;
                m = (gr(xw, i) < gr(ref_r[i], j)) ? gr(xw, i) : gr(ref_r[i], j);
                if (m > res[j*4 +: 4]) res[j*4 +: 4] = m;
            end
        end
        return res;
    endfunction

    task automatic check_rules(input string req);
        for (int r = 0; r < 8; r++) begin
            rd_addr = 3'(r);
            #1;
            chk(rd_row == ref_r[r], req, rd_row, ref_r[r]);
        end
    endtask

    // Driver: pushes the expected z_out for the run's done pulse into the scoreboard.
    task automatic run_op(input logic m, input logic [31:0] xw, input logic [31:0] zw,
                          input bit disturb, input string req);
        int cnt;
        if (m) ref_zout = ref_infer(xw);
        else ref_build(xw, zw);
        expq.push_back(ref_zout);
        @(negedge clk);
        start = 1'b1; mode = m; x_word = xw; z_word = zw;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1 && done == 1'b0, "R5 busy after accept", {31'd0, busy}, 32'd1);
        if (disturb) begin // R7, R11: restart attempt with inverted operands and mode
            start = 1'b1; mode = ~m; x_word = ~xw; z_word = ~zw;
        end
        cnt = 1;
        while (!done && cnt < 40) begin
            @(negedge clk);
            cnt++;
            if (cnt == 3) start = 1'b0;
        end
        chk(cnt == 9, {req, " R5 done latency"}, 32'(cnt), 32'd9);
        chk(busy == 1'b0, "R5 busy low at done", {31'd0, busy}, 32'd0);
        @(negedge clk);
        chk(done == 1'b0, "R5 done single cycle", {31'd0, done}, 32'd0);
        chk(z_out == ref_zout, {req, " R6 z_out held"}, z_out, ref_zout);
    endtask

    // Monitor: compares z_out against the scoreboard at each done pulse.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R8 unexpected done", 32'd1, 32'd0);
            end else begin
                logic [31:0] e;
                e = expq.pop_front();
                chk(z_out == e, "R4/R6 scoreboard z_out", z_out, e);
            end
        end
    end

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        finish_up();
    end

    initial begin
        for (int i = 0; i < 8; i++) ref_r[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state, R10 read port
        chk(busy == 1'b0 && done == 1'b0, "R9 idle after reset", {30'd0, busy, done}, 32'd0);
        chk(z_out == '0, "R9 z_out zero", z_out, 32'd0);
        check_rules("R9/R10 rules zero");

        // R2 first build run
        run_op(1'b0, 32'h3F0A_9C51, 32'h0287_F6D4, 1'b0, "R2 build");
        check_rules("R2 rule rows");
        // R4 inference
        run_op(1'b1, 32'hA5F0_37C2, 32'h0, 1'b0, "R4 infer");
        // R3 accumulation with a second build
        run_op(1'b0, 32'hC041_7E2F, 32'h9E3B_0FA6, 1'b0, "R3 build2");
        check_rules("R3 merged rules");
        // R7, R11: start re-pulsed and operands changed during the run
        run_op(1'b1, 32'h5B6E_19D3, 32'h0, 1'b1, "R7/R11 infer");
        run_op(1'b0, 32'h1111_2222, 32'hF0F0_0F0F, 1'b1, "R7/R11 build");
        check_rules("R11 rules after disturbed build");
        // R1 single-element selection: only grade 7 set, result is row 7
        run_op(1'b1, 32'hF000_0000, 32'h0, 1'b0, "R1 elem7");
        chk(z_out == ref_r[7], "R1 row7 selected", z_out, ref_r[7]);
        run_op(1'b1, 32'h0000_000F, 32'h0, 1'b0, "R1 elem0");
        chk(z_out == ref_r[0], "R1 row0 selected", z_out, ref_r[0]);
        // R4 boundaries
        run_op(1'b1, 32'h0000_0000, 32'h0, 1'b0, "R4 zero X");
        run_op(1'b1, 32'hFFFF_FFFF, 32'h0, 1'b0, "R4 full X");

        // R8 clear in the middle of a build run
        @(negedge clk);
        start = 1'b1; mode = 1'b0; x_word = 32'hFFFF_FFFF; z_word = 32'hFFFF_FFFF;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        chk(busy == 1'b0, "R8 run aborted", {31'd0, busy}, 32'd0);
        for (int i = 0; i < 8; i++) ref_r[i] = '0;
        repeat (12) @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R8 no done after clear", {30'd0, busy, done}, 32'd0);
        check_rules("R8 rules cleared");
        chk(z_out == ref_zout, "R8 z_out kept", z_out, ref_zout);
        run_op(1'b1, 32'hFFFF_FFFF, 32'h0, 1'b0, "R8 infer after clear");
        chk(z_out == '0, "R8 empty rules give zero", z_out, 32'd0);

        // R8 clear has priority over start
        @(negedge clk);
        start = 1'b1; clear = 1'b1; mode = 1'b0;
        @(negedge clk);
        start = 1'b0; clear = 1'b0;
        chk(busy == 1'b0, "R8 clear beats start", {31'd0, busy}, 32'd0);
        repeat (3) @(negedge clk);
        chk(expq.size() == 0, "scoreboard drained", 32'(expq.size()), 32'd0);
        finish_up();
    end
endmodule